// File: doc/BRIEF.md
# Eight-Bit Registered ALU With Held Flags

This unit is the arithmetic and logic stage of a small accumulator-style processor. On every clock edge it takes two operands and a four-bit operation code, works out one of sixteen operations, and registers both the result and three status flags: carry, zero and sign. The processor's conditional branches test these flags, so a compare can be issued as a subtract and a bit test as an AND, with the result thrown away and only the flags kept.

The carry flag is kept from one operation to the next. Add-with-carry, subtract-with-borrow and the two rotate-through-carry operations take their incoming carry from it, so multi-byte arithmetic and wide shifts can be built from a sequence of operations. Increment and decrement are an add or a subtract with the second operand set to one. The operand width is a parameter with a default of eight bits.

Top module: `aluCore`

## Requirements
- R1: A synchronous active-high reset clears the result and all three flags to zero.
- R2: Operands and operation code applied before a clock edge are reflected in the result and flags right after that edge. The latency is one register.
- R3: Code 0000 adds A and B. Code 0010 adds A, B and the held carry. In both, the carry flag takes the carry out of the top bit.
- R4: Code 0001 gives A minus B. Code 0011 gives A minus B minus the held carry. The carry flag is set as a borrow when unsigned A is less than B plus the borrow-in.
- R5: Codes 0100, 0101, 0110 and 0111 give A AND B, A OR B, NOT B and A XOR B, in that order. All four clear the carry flag.
- R6: Code 1000 (logical left) and code 1010 (arithmetic left) shift A left by one and put 0 in bit 0. The old top bit goes to the carry flag.
- R7: Code 1001 shifts A right by one and puts 0 in the top bit. Code 1011 shifts A right by one and keeps the top bit. Both move the old bit 0 into the carry flag.
- R8: Code 1100 rotates A left and code 1101 rotates A right, both within the operand width. The bit rotated out is copied into the carry flag.
- R9: Code 1110 rotates A left and code 1111 rotates A right, each through the carry flag as an extra bit. The held carry enters the vacated bit, and the bit shifted out becomes the new carry.
- R10: For codes 1000 to 1111, operand B has no effect on the result or the flags.
- R11: After every operation, the zero flag is set exactly when the result is zero, and the sign flag equals the top bit of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | WIDTH | First operand; the only operand for shifts and rotates |
| opB | input | WIDTH | Second operand |
| opCode | input | 4 | Operation select |
| result | output | WIDTH | Registered result |
| carryFlag | output | 1 | Registered carry or borrow flag |
| zeroFlag | output | 1 | Registered zero flag |
| signFlag | output | 1 | Registered sign flag |

## Verification
The bench goes after the carry chain. Add-with-carry and subtract-with-borrow with the held carry set are swept across every first operand. A design that inverted the borrow sense, or that ignored the held carry, would be off by one on every such sum. The bench also checks the edge cases zero minus one with borrow and 255 plus 255 plus carry.

The right shifts and the rotates are compared bit by bit. A design that confused the arithmetic right shift with the logical one would lose the sign bit on negative values. A design that rotated through carry in the wrong direction would corrupt the top or bottom bit. A separate pass changes only operand B under every shift and rotate, to catch decode that leaks B into the result. A reset issued after the carry has been set must clear it, or the next add-with-carry comes out one too high.

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'b0000,
    OP_SUB = 4'b0001,
    OP_ADC = 4'b0010,
    OP_SBC = 4'b0011,
    OP_AND = 4'b0100,
    OP_OR  = 4'b0101,
    OP_NOT = 4'b0110,
    OP_XOR = 4'b0111,
    OP_SHL = 4'b1000,
    OP_SHR = 4'b1001,
    OP_SAL = 4'b1010,
    OP_SAR = 4'b1011,
    OP_ROL = 4'b1100,
    OP_ROR = 4'b1101,
    OP_RCL = 4'b1110,
    OP_RCR = 4'b1111
  } aluOp_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_NOT = 2'd2,
    LF_XOR = 2'd3
  } logicFn_e;

  typedef enum logic [2:0] {
    SF_SHL = 3'd0,
    SF_SHR = 3'd1,
    SF_SAL = 3'd2,
    SF_SAR = 3'd3,
    SF_ROL = 3'd4,
    SF_ROR = 3'd5,
    SF_RCL = 3'd6,
    SF_RCR = 3'd7
  } shiftFn_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     doArith;
    logic     doLogic;
    logic     doShift;
    logic     subtract;
    logic     chainCarry;
    logicFn_e logicFn;
    shiftFn_e shiftFn;
  } aluStrobes_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobes_t     strobes
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    strobes            = '0;
    strobes.logicFn    = LF_AND;
    strobes.shiftFn    = SF_SHL;
    unique case (op)
      OP_ADD: strobes.doArith = 1'b1;
      OP_SUB: begin
        strobes.doArith  = 1'b1;
        strobes.subtract = 1'b1;
      end
      OP_ADC: begin
        strobes.doArith    = 1'b1;
        strobes.chainCarry = 1'b1;
      end
      OP_SBC: begin
        strobes.doArith    = 1'b1;
        strobes.subtract   = 1'b1;
        strobes.chainCarry = 1'b1;
      end
      OP_AND: begin strobes.doLogic = 1'b1; strobes.logicFn = LF_AND; end
      OP_OR:  begin strobes.doLogic = 1'b1; strobes.logicFn = LF_OR;  end
      OP_NOT: begin strobes.doLogic = 1'b1; strobes.logicFn = LF_NOT; end
      OP_XOR: begin strobes.doLogic = 1'b1; strobes.logicFn = LF_XOR; end
      OP_SHL: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_SHL; end
      OP_SHR: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_SHR; end
      OP_SAL: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_SAL; end
      OP_SAR: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_SAR; end
      OP_ROL: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_ROL; end
      OP_ROR: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_ROR; end
      OP_RCL: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_RCL; end
      OP_RCR: begin strobes.doShift = 1'b1; strobes.shiftFn = SF_RCR; end
      default: strobes.doLogic = 1'b1;
    endcase
  end

  // Exactly one unit is selected for every code
  always_comb begin
    assert_one_unit_R2: assert ($countones({strobes.doArith, strobes.doLogic, strobes.doShift}) <= 1)
      else $error("more than one unit selected");
  end

endmodule

// File: rtl/aluShifter.sv
module aluShifter
  import aluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] valIn,
  input  logic             carryIn,
  input  shiftFn_e         fn,
  output logic [WIDTH-1:0] valOut,
  output logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic topBit;
  logic lowBit;
  assign topBit = valIn[MSB];
  assign lowBit = valIn[0];

  always_comb begin
    valOut   = valIn;
    carryOut = 1'b0;
    unique case (fn)
      SF_SHL, SF_SAL: begin
        valOut   = {valIn[MSB-1:0], 1'b0};
        carryOut = topBit;
      end
      SF_SHR: begin
        valOut   = {1'b0, valIn[MSB:1]};
        carryOut = lowBit;
      end
      SF_SAR: begin
        valOut   = {topBit, valIn[MSB:1]};
        carryOut = lowBit;
      end
      SF_ROL: begin
        valOut   = {valIn[MSB-1:0], topBit};
        carryOut = topBit;
      end
      SF_ROR: begin
        valOut   = {lowBit, valIn[MSB:1]};
        carryOut = lowBit;
      end
      SF_RCL: begin
        valOut   = {valIn[MSB-1:0], carryIn};
        carryOut = topBit;
      end
      SF_RCR: begin
        valOut   = {carryIn, valIn[MSB:1]};
        carryOut = lowBit;
      end
      default: begin
        valOut   = valIn;
        carryOut = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             zeroFlag,
  output logic             signFlag
);

  localparam int MSB = WIDTH - 1;

  // Adder: subtraction as A + ~B + 1 - borrowIn
  logic [WIDTH-1:0] addendB;
  logic             addCin;
  logic [WIDTH:0]   sumExt;
  logic             arithCarry;

  assign addendB    = strobes.subtract ? ~opB : opB;
  assign addCin     = strobes.subtract ? ~(strobes.chainCarry & carryFlag)
                                       :  (strobes.chainCarry & carryFlag);
  assign sumExt     = {1'b0, opA} + {1'b0, addendB} + {{WIDTH{1'b0}}, addCin};
  assign arithCarry = strobes.subtract ? ~sumExt[WIDTH] : sumExt[WIDTH];

  // Logic unit
  logic [WIDTH-1:0] logicVal;
  always_comb begin
    unique case (strobes.logicFn)
      LF_AND:  logicVal = opA & opB;
      LF_OR:   logicVal = opA | opB;
      LF_NOT:  logicVal = ~opB;
      LF_XOR:  logicVal = opA ^ opB;
      default: logicVal = '0;
    endcase
  end

  // Shift and rotate unit
  logic [WIDTH-1:0] shiftVal;
  logic             shiftCarry;

  aluShifter #(.WIDTH(WIDTH)) u_shifter (
    .valIn    (opA),
    .carryIn  (carryFlag),
    .fn       (strobes.shiftFn),
    .valOut   (shiftVal),
    .carryOut (shiftCarry)
  );

  // Result select
  logic [WIDTH-1:0] nextResult;
  logic             nextCarry;

  always_comb begin
    nextResult = logicVal;
    nextCarry  = 1'b0;
    if (strobes.doArith) begin
      nextResult = sumExt[MSB:0];
      nextCarry  = arithCarry;
    end else if (strobes.doShift) begin
      nextResult = shiftVal;
      nextCarry  = shiftCarry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
      signFlag  <= 1'b0;
    end else begin
      result    <= nextResult;
      carryFlag <= nextCarry;
      zeroFlag  <= (nextResult == '0);
      signFlag  <= nextResult[MSB];
    end
  end

  // Marks that the last edge computed an operation rather than reset
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (rst)
    primed && $past(strobes.doArith && !strobes.subtract && !strobes.chainCarry)
      |-> ({carryFlag, result} == ({1'b0, $past(opA)} + {1'b0, $past(opB)})));

  assert_sbc_borrow_R4: assert property (@(posedge clk) disable iff (rst)
    primed && $past(strobes.doArith && strobes.subtract && strobes.chainCarry)
      |-> (carryFlag == ({1'b0, $past(opA)} <
                         ({1'b0, $past(opB)} + {{WIDTH{1'b0}}, $past(carryFlag)}))));

  assert_logic_clears_carry_R5: assert property (@(posedge clk) disable iff (rst)
    primed && $past(strobes.doLogic) |-> !carryFlag);

  assert_rol_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    primed && $past(strobes.doShift && strobes.shiftFn == SF_ROL)
      |-> (result == {$past(opA[MSB-1:0]), $past(opA[MSB])}) && (carryFlag == $past(opA[MSB])));

endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             carryFlag,
  output logic             zeroFlag,
  output logic             signFlag
);

  aluStrobes_t strobes;

  aluCtrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .opA       (opA),
    .opB       (opB),
    .strobes   (strobes),
    .result    (result),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag),
    .signFlag  (signFlag)
  );

endmodule

// File: tb/test_aluCore.sv
module test_aluCore;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [3:0]   opCode = '0;
  logic [W-1:0] result;
  logic         carryFlag, zeroFlag, signFlag;

  int checks = 0;
  int errors = 0;
  int modelCf = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aluCore #(.WIDTH(W)) i_aluCore (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .carryFlag(carryFlag), .zeroFlag(zeroFlag), .signFlag(signFlag)
  );

  function automatic string reqTag(int op);
    case (op)
      0, 2:          return "R3";
      1, 3:          return "R4";
      4, 5, 6, 7:    return "R5";
      8, 10:         return "R6";
      9, 11:         return "R7";
      12, 13:        return "R8";
      default:       return "R9";
    endcase
  endfunction

  // Arithmetic reference: returns {carry, result} as an integer
  function automatic int refModel(int op, int a, int b, int cin);
    int r;
    int c;
    r = 0; c = 0;
    case (op)
      0:  begin r = a + b; c = (r > 255); r = r % 256; end
      2:  begin r = a + b + cin; c = (r > 255); r = r % 256; end
      1:  begin c = (a < b); r = (a - b + 256) % 256; end
      3:  begin c = (a < b + cin); r = (a - b - cin + 512) % 256; end
      4:  r = a & b;
      5:  r = a | b;
      6:  r = 255 - b;
      7:  r = a ^ b;
      8, 10: begin r = (a * 2) % 256; c = a / 128; end
      9:  begin r = a / 2; c = a % 2; end
      11: begin r = a / 2 + ((a >= 128) ? 128 : 0); c = a % 2; end
      12: begin r = (a * 2) % 256 + a / 128; c = a / 128; end
      13: begin r = a / 2 + (a % 2) * 128; c = a % 2; end
      14: begin r = (a * 2) % 256 + cin; c = a / 128; end
      default: begin r = a / 2 + cin * 128; c = a % 2; end
    endcase
    return c * 256 + r;
  endfunction

  task automatic checkVal(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Called at a negedge; applies one operation, samples at the next negedge
  task automatic doOp(int op, int a, int b);
    int e;
    int er;
    opCode = op[3:0]; opA = a[W-1:0]; opB = b[W-1:0];
    @(posedge clk);
    @(negedge clk);
    e  = refModel(op, a, b, modelCf);
    er = e % 256;
    checkVal(reqTag(op), "result", int'(result), er);
    checkVal(reqTag(op), "carry", int'(carryFlag), e / 256);
    checkVal("R11", "zero", int'(zeroFlag), (er == 0) ? 1 : 0);
    checkVal("R11", "sign", int'(signFlag), er / 128);
    modelCf = e / 256;
  endtask

  task automatic resetCheck();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkVal("R1", "result", int'(result), 0);
    checkVal("R1", "carry", int'(carryFlag), 0);
    checkVal("R1", "zero", int'(zeroFlag), 0);
    checkVal("R1", "sign", int'(signFlag), 0);
    rst = 1'b0;
    modelCf = 0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    resetCheck();

    // R2: a single add is visible right after the capturing edge
    doOp(0, 3, 4);
    checkVal("R2", "latency", int'(result), 7);

    // Corner cases of the carry chain
    doOp(0, 255, 1);        // carry out, zero result
    doOp(2, 255, 255);      // ADC with carry set
    doOp(1, 0, 1);          // borrow
    doOp(3, 0, 0);          // SBC with borrow in
    doOp(3, 0, 255);
    doOp(14, 8'h81, 0);     // RCL through carry
    doOp(15, 8'h02, 0);     // RCR through carry

    // Sweep: every code, every A, sixteen B values; carry follows the sequence
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 16; bi++)
          doOp(op, a, (bi * 17 + a) % 256);

    // R10: shifts and rotates with B varied only
    for (int op = 8; op < 16; op++)
      for (int a = 0; a < 256; a += 5) begin
        int r0;
        int c0;
        doOp(0, 200, 100);   // sets carry
        doOp(op, a, 0);
        r0 = int'(result); c0 = int'(carryFlag);
        doOp(0, 200, 100);
        doOp(op, a, 255);
        checkVal("R10", "result vs B", int'(result), r0);
        checkVal("R10", "carry vs B", int'(carryFlag), c0);
      end

    // R1: reset after the carry is set clears it; the next ADC adds no carry
    doOp(0, 255, 255);
    resetCheck();
    doOp(2, 10, 20);
    checkVal("R1", "adc after reset", int'(result), 30);

    done = 1'b1;
  end

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected done", cyc);
    end
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule